// File: doc/BRIEF.md
# CPU Clock Enable Generator with Ring-Oscillator Stop Control

This block produces the processor clock enable for a small 8-bit microcontroller. All clocking is modelled as single-cycle enables on one reference clock. The main clock rate is the reference clock itself, and the enable can run at that rate divided by 1, 2, 4, 8 or 16. A separate low-speed subsystem tick can be chosen instead, in which case the enable fires on every second subsystem tick. The fastest instruction takes two enables, so the shortest instruction time is twice the selected enable period.

A free-running prescaler is shared by all main-clock ratios. A new choice of ratio or source is only adopted when the prescaler wraps, which is the point where every ratio fires together. This means a selection change never produces a shortened enable period.

The block also holds a one-bit oscillator mode register on a simple register bus. Software sets its stop bit to request that the internal ring oscillator halt. The request is honoured only when two things hold: a build-time parameter allows the oscillator to be stopped, and the processor is running from the crystal or from the subsystem clock. Otherwise the bit is stored but the oscillator run output stays high.

Top module: `cpu_clk_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the mode register reads 00H, `ring_run` is 1, the active source is the main clock and the active ratio is divide-by-16.
- R2: The mode register decodes at address FFA0H (parameter `REG_ADDR`) and reads as `{7'b0, stop}`. Reads of any other address return 00H, and writes or bit operations to any other address change nothing.
- R3: A byte write loads the stop bit from write-data bit 0. A bit set or bit clear with bit position 0 sets or clears the stop bit, and other bit positions have no effect. In one cycle, a byte write wins over a set, and a set wins over a clear.
- R4: With the main source active and ratio code k (0 to 4), `cpu_ce` is a one-cycle pulse in every cycle where the low k bits of the 4-bit prescaler are all ones, which gives one pulse per 2^k cycles. Codes 5 to 7 act as code 4.
- R5: With the subsystem source active, `cpu_ce` pulses only together with `sub_tick`, on the 2nd, 4th, 6th and later ticks counted since reset.
- R6: Changes on `div_sel` and `sub_sel` are adopted only in the cycle in which the prescaler equals 15. They govern the enable from the following cycle on.
- R7: With `STOP_ALLOWED` = 0, `ring_run` stays 1 whatever the register holds.
- R8: With `STOP_ALLOWED` = 1, `ring_run` is 0 exactly when the stop bit is 1 and either `main_xtal_sel` is 1 or the active source is the subsystem. A stop bit written while neither holds stays stored and takes effect once one of them holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 16 | Register bus address |
| bus_wr | input | 1 | Byte write strobe |
| bus_wdata | input | 8 | Byte write data |
| bus_bset | input | 1 | Single-bit set strobe |
| bus_bclr | input | 1 | Single-bit clear strobe |
| bus_bpos | input | 3 | Bit position for set/clear |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| main_xtal_sel | input | 1 | Main clock status: 1 = crystal, 0 = ring oscillator |
| sub_sel | input | 1 | Requested CPU source: 1 = subsystem clock |
| div_sel | input | 3 | Requested main-clock ratio code |
| sub_tick | input | 1 | Subsystem clock enable, one cycle wide |
| cpu_ce | output | 1 | CPU clock enable pulse |
| ring_run | output | 1 | Ring oscillator run request |

## Verification
The bench builds two instances side by side on shared stimulus. One uses `STOP_ALLOWED` = 1 and the other uses `STOP_ALLOWED` = 0, with the default 4-bit prescaler. The pair makes the honoured stop and the ignored stop observable in the same cycles under identical register traffic. The default prescaler width keeps every ratio, including the divide-by-16 adoption point, within a few dozen cycles, so each ratio code and mid-period selection changes are covered many times over.

// File: rtl/cc_pkg.sv
// Package: shared types and constants for the CPU clock enable generator.
// Assumes ratio codes fit in three bits (prescaler width up to 7).
package cc_pkg;
    localparam int unsigned RATIO_W = 3;
    localparam int unsigned N_CODES = 1 << RATIO_W;

    typedef logic [RATIO_W-1:0] ratio_t;

    // Active clock configuration, adopted only at a prescaler wrap.
    typedef struct packed {
        logic   use_sub;
        ratio_t ratio;
    } clk_cfg_t;
endpackage

// File: rtl/cc_regfile.sv
// Oscillator mode register: one stored stop bit behind a byte/bit bus.
// Assumes a single address decode; all other addresses read zero.
module cc_regfile #(
    parameter int unsigned      ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] REG_ADDR = 16'hFFA0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [7:0]        wdata,
    input  logic              bset,
    input  logic              bclr,
    input  logic [2:0]        bpos,
    output logic [7:0]        rdata,
    output logic              stop_q
);
    logic sel;
    logic bit0_hit;

    // Decode of the register address and of bit position 0.
    always_comb begin
        sel      = (addr == REG_ADDR);
        bit0_hit = (bpos == 3'd0);
    end

    // Stop bit update: byte write over set over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_q <= 1'b0;
        end else if (sel) begin
            if (wr) begin
                stop_q <= wdata[0];
            end else if (bset && bit0_hit) begin
                stop_q <= 1'b1;
            end else if (bclr && bit0_hit) begin
                stop_q <= 1'b0;
            end
        end
    end

    // Read mux: register contents or zero.
    always_comb begin
        rdata = sel ? {7'b0, stop_q} : 8'h00;
    end
endmodule

// File: rtl/cc_prescaler.sv
// Free-running prescaler shared by every main-clock ratio.
// Assumes the slowest ratio equals the full prescaler period.
module cc_prescaler #(
    parameter int unsigned PRE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [PRE_W-1:0] pre,
    output logic             wrap
);
    // Count up every reference cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre <= '0;
        end else begin
            pre <= pre + 1'b1;
        end
    end

    // Wrap marks the cycle in which every ratio fires together.
    always_comb begin
        wrap = &pre;
    end
endmodule

// File: rtl/cc_cfg_latch.sv
// Holds the active source and ratio; adopts new requests only at wrap.
// Assumes ratio codes above PRE_W mean the slowest ratio.
module cc_cfg_latch
    import cc_pkg::*;
#(
    parameter int unsigned PRE_W = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wrap,
    input  logic     sub_req,
    input  ratio_t   ratio_req,
    output clk_cfg_t cfg
);
    localparam ratio_t MAX_CODE = ratio_t'(PRE_W);

    ratio_t ratio_clamped;

    // Clamp out-of-range codes to the slowest ratio.
    always_comb begin
        ratio_clamped = (ratio_req > MAX_CODE) ? MAX_CODE : ratio_req;
    end

    // Adopt the requested configuration at the prescaler wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg.use_sub <= 1'b0;
            cfg.ratio   <= MAX_CODE;
        end else if (wrap) begin
            cfg.use_sub <= sub_req;
            cfg.ratio   <= ratio_clamped;
        end
    end
endmodule

// File: rtl/cc_ce_mux.sv
// Builds one enable per ratio from the prescaler, plus the half-rate
// subsystem enable, and picks the active one.
// Assumes sub_tick is a one-cycle pulse in the reference domain.
module cc_ce_mux
    import cc_pkg::*;
#(
    parameter int unsigned PRE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PRE_W-1:0] pre,
    input  clk_cfg_t         cfg,
    input  logic             sub_tick,
    output logic             cpu_ce
);
    logic [N_CODES-1:0] hit;
    logic               sub_ph;
    logic               main_ce;
    logic               sub_ce;

    // One candidate enable per ratio code; unused codes stay low.
    for (genvar k = 0; k < N_CODES; k++) begin : g_ratio
        if (k <= PRE_W) begin : g_live
            localparam int unsigned MASK_I = (1 << k) - 1;
            localparam logic [PRE_W-1:0] MASK = MASK_I[PRE_W-1:0];
            assign hit[k] = ((pre & MASK) == MASK);
        end else begin : g_dead
            assign hit[k] = 1'b0;
        end
    end

    // Subsystem phase toggles on every tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sub_ph <= 1'b0;
        end else if (sub_tick) begin
            sub_ph <= ~sub_ph;
        end
    end

    // Select between main ratio and half-rate subsystem enable.
    always_comb begin
        main_ce = hit[cfg.ratio];
        sub_ce  = sub_tick & sub_ph;
        cpu_ce  = cfg.use_sub ? sub_ce : main_ce;
    end
endmodule

// File: rtl/cc_ring_guard.sv
// Decides whether the ring oscillator may run.
// Assumes the stop request is only safe when the CPU is off the ring clock.
module cc_ring_guard #(
    parameter bit STOP_ALLOWED = 1'b1
) (
    input  logic stop_q,
    input  logic main_xtal_sel,
    input  logic use_sub,
    output logic ring_run
);
    if (STOP_ALLOWED) begin : g_stoppable
        // Honour the stop bit only while the CPU runs off crystal or subsystem.
        always_comb begin
            ring_run = ~(stop_q & (main_xtal_sel | use_sub));
        end
    end else begin : g_locked
        // Oscillator cannot be stopped in this build.
        always_comb begin
            ring_run = 1'b1;
        end
    end
endmodule

// File: rtl/cpu_clk_ctrl.sv
// Top: CPU clock enable generator with oscillator stop register.
// Assumes all clocks are modelled as enables on the reference clock.
module cpu_clk_ctrl
    import cc_pkg::*;
#(
    parameter int unsigned       ADDR_W       = 16,
    parameter logic [ADDR_W-1:0] REG_ADDR     = 16'hFFA0,
    parameter int unsigned       PRE_W        = 4,
    parameter bit                STOP_ALLOWED = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_bset,
    input  logic              bus_bclr,
    input  logic [2:0]        bus_bpos,
    output logic [7:0]        bus_rdata,
    input  logic              main_xtal_sel,
    input  logic              sub_sel,
    input  logic [2:0]        div_sel,
    input  logic              sub_tick,
    output logic              cpu_ce,
    output logic              ring_run
);
    logic             stop_q;
    logic [PRE_W-1:0] pre;
    logic             wrap;
    clk_cfg_t         cfg;

    cc_regfile #(
        .ADDR_W   (ADDR_W),
        .REG_ADDR (REG_ADDR)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (bus_addr),
        .wr     (bus_wr),
        .wdata  (bus_wdata),
        .bset   (bus_bset),
        .bclr   (bus_bclr),
        .bpos   (bus_bpos),
        .rdata  (bus_rdata),
        .stop_q (stop_q)
    );

    cc_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .pre   (pre),
        .wrap  (wrap)
    );

    cc_cfg_latch #(.PRE_W(PRE_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wrap      (wrap),
        .sub_req   (sub_sel),
        .ratio_req (ratio_t'(div_sel)),
        .cfg       (cfg)
    );

    cc_ce_mux #(.PRE_W(PRE_W)) u_ce (
        .clk      (clk),
        .rst_n    (rst_n),
        .pre      (pre),
        .cfg      (cfg),
        .sub_tick (sub_tick),
        .cpu_ce   (cpu_ce)
    );

    cc_ring_guard #(.STOP_ALLOWED(STOP_ALLOWED)) u_guard (
        .stop_q        (stop_q),
        .main_xtal_sel (main_xtal_sel),
        .use_sub       (cfg.use_sub),
        .ring_run      (ring_run)
    );
endmodule

// File: rtl/cpu_clk_ctrl_chk.sv
// Checker for cpu_clk_ctrl, attached by bind below.
module cpu_clk_ctrl_chk #(
    parameter int unsigned       ADDR_W       = 16,
    parameter logic [ADDR_W-1:0] REG_ADDR     = 16'hFFA0,
    parameter int unsigned       PRE_W        = 4,
    parameter bit                STOP_ALLOWED = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_rdata,
    input logic              main_xtal_sel,
    input logic              sub_tick,
    input logic              cpu_ce,
    input logic              ring_run,
    input logic              stop_q,
    input logic              wrap,
    input logic              use_sub,
    input logic [2:0]        ratio
);
    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (stop_q == 1'b0 && ring_run));

    assert_undef_read_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != REG_ADDR) |-> (bus_rdata == 8'h00));

    assert_upper_bits_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[7:1] == 7'b0);

    assert_main_pulse_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!use_sub && cpu_ce && ratio != 3'd0 && !wrap) |=> !cpu_ce);

    assert_sub_needs_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (use_sub && cpu_ce) |-> sub_tick);

    assert_cfg_at_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !($stable(use_sub) && $stable(ratio)) |-> $past(wrap));

    if (!STOP_ALLOWED) begin : g_locked
        assert_locked_runs_R7: assert property (@(posedge clk) disable iff (!rst_n)
            stop_q |-> ring_run);
    end else begin : g_free
        assert_stop_guard_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !ring_run |-> (stop_q && (main_xtal_sel || use_sub)));
    end
endmodule

bind cpu_clk_ctrl cpu_clk_ctrl_chk #(
    .ADDR_W       (ADDR_W),
    .REG_ADDR     (REG_ADDR),
    .PRE_W        (PRE_W),
    .STOP_ALLOWED (STOP_ALLOWED)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_addr      (bus_addr),
    .bus_rdata     (bus_rdata),
    .main_xtal_sel (main_xtal_sel),
    .sub_tick      (sub_tick),
    .cpu_ce        (cpu_ce),
    .ring_run      (ring_run),
    .stop_q        (stop_q),
    .wrap          (wrap),
    .use_sub       (cfg.use_sub),
    .ratio         (cfg.ratio)
);

// File: tb/test_cpu_clk_ctrl.sv
// Bench: two builds (stop allowed / locked) against a behavioural model.
module test_cpu_clk_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = 16'h0000;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = 8'h00;
    logic        bus_bset = 1'b0;
    logic        bus_bclr = 1'b0;
    logic [2:0]  bus_bpos = 3'd0;
    logic        main_xtal_sel = 1'b0;
    logic        sub_sel = 1'b0;
    logic [2:0]  div_sel = 3'd0;
    logic        sub_tick = 1'b0;
    logic [7:0]  rdata_a, rdata_b;
    logic        ce_a, ce_b, ring_a, ring_b;

    int    errors = 0;
    int    checks = 0;
    int    cycle  = 0;
    bit    done   = 0;
    bit    valid  = 0;
    string phase  = "R1";

    // Behavioural reference state.
    int m_pre, m_ratio, m_stop;
    bit m_sub, m_ph;
    logic [7:0] lfsr = 8'h5A;

    always #(CLK_PERIOD/2) clk = ~clk;

    cpu_clk_ctrl #(.STOP_ALLOWED(1'b1)) i_cpu_clk_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_bset(bus_bset), .bus_bclr(bus_bclr),
        .bus_bpos(bus_bpos), .bus_rdata(rdata_a), .main_xtal_sel(main_xtal_sel),
        .sub_sel(sub_sel), .div_sel(div_sel), .sub_tick(sub_tick),
        .cpu_ce(ce_a), .ring_run(ring_a));

    cpu_clk_ctrl #(.STOP_ALLOWED(1'b0)) i_cpu_clk_ctrl_locked (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_bset(bus_bset), .bus_bclr(bus_bclr),
        .bus_bpos(bus_bpos), .bus_rdata(rdata_b), .main_xtal_sel(main_xtal_sel),
        .sub_sel(sub_sel), .div_sel(div_sel), .sub_tick(sub_tick),
        .cpu_ce(ce_b), .ring_run(ring_b));

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at cycle %0d", tag, what, act, exp, cycle);
        end
    endtask

    // Model update on each edge from the inputs present at the edge.
    always @(posedge clk) begin
        cycle++;
        if (!rst_n) begin
            m_pre = 0; m_ratio = 4; m_sub = 0; m_ph = 0; m_stop = 0;
            valid = 1;
        end else begin
            if (m_pre == 15) begin
                m_ratio = (div_sel > 4) ? 4 : int'(div_sel);
                m_sub   = sub_sel;
            end
            m_pre = (m_pre + 1) % 16;
            if (sub_tick) m_ph = !m_ph;
            if (bus_addr == 16'hFFA0) begin
                if (bus_wr) m_stop = bus_wdata[0];
                else if (bus_bset && bus_bpos == 0) m_stop = 1;
                else if (bus_bclr && bus_bpos == 0) m_stop = 0;
            end
        end
        if (cycle > WATCHDOG && !done) begin
            errors++;
            $display("FAIL watchdog expired at cycle %0d", cycle);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    // Subsystem tick pattern, changed just after each edge.
    always @(posedge clk) begin
        #1;
        lfsr     <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        sub_tick <= lfsr[0] & lfsr[2];
    end

    // Per-cycle compare at the falling edge.
    always @(negedge clk) begin
        if (valid) begin
            bit exp_ce, exp_ring;
            exp_ce   = m_sub ? (sub_tick && m_ph)
                             : (((m_pre + 1) % (1 << m_ratio)) == 0);
            exp_ring = !(m_stop == 1 && (main_xtal_sel || m_sub));
            check(phase, "cpu_ce (R4 R5 R6)", int'(ce_a), int'(exp_ce));
            check(phase, "cpu_ce locked build", int'(ce_b), int'(exp_ce));
            check(phase, "ring_run (R8)", int'(ring_a), int'(exp_ring));
            check(phase, "ring_run locked (R7)", int'(ring_b), 1);
            check(phase, "rdata (R2)", int'(rdata_a),
                  (bus_addr == 16'hFFA0) ? m_stop : 0);
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_op(input logic [15:0] a, input bit w, input logic [7:0] d,
                          input bit s, input bit c, input logic [2:0] p);
        bus_addr = a; bus_wr = w; bus_wdata = d; bus_bset = s; bus_bclr = c; bus_bpos = p;
        step(1);
        bus_wr = 0; bus_bset = 0; bus_bclr = 0;
        bus_addr = 16'hFFA0;
        @(negedge clk);
    endtask

    initial begin
        step(3);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        check("R1", "rdata after reset", int'(rdata_a), 0);
        check("R1", "ring_run after reset", int'(ring_a), 1);
        step(0);

        // R4: every ratio code including out-of-range ones
        phase = "R4";
        for (int code = 0; code < 8; code++) begin
            div_sel = 3'(code);
            step(48);
        end

        // R6: changes in the middle of periods
        phase = "R6";
        div_sel = 3'd1; step(5);
        div_sel = 3'd3; step(3);
        div_sel = 3'd0; step(7);
        div_sel = 3'd4; step(11);
        div_sel = 3'd2; step(40);

        // R5: subsystem source
        phase = "R5";
        sub_sel = 1; step(120);
        sub_sel = 0; step(40);

        // R2: other addresses ignored and read zero
        phase = "R2";
        bus_op(16'hFFA1, 1, 8'hFF, 0, 0, 3'd0);
        check("R2", "write to FFA1 ignored", int'(rdata_a), 0);
        bus_op(16'hFFA1, 0, 8'h00, 1, 0, 3'd0);
        check("R2", "bit set to FFA1 ignored", int'(rdata_a), 0);
        bus_addr = 16'hFFA1; bus_op(16'hFFA0, 1, 8'h01, 0, 0, 3'd0);
        bus_addr = 16'h1234; #1;
        check("R2", "read of undefined address", int'(rdata_a), 0);
        bus_op(16'hFFA0, 1, 8'h00, 0, 0, 3'd0);

        // R3: byte and bit operations
        phase = "R3";
        bus_op(16'hFFA0, 1, 8'hFE, 0, 0, 3'd0);
        check("R3", "byte write FEh", int'(rdata_a), 0);
        bus_op(16'hFFA0, 1, 8'h01, 0, 0, 3'd0);
        check("R3", "byte write 01h", int'(rdata_a), 1);
        bus_op(16'hFFA0, 0, 8'h00, 0, 1, 3'd3);
        check("R3", "clear bit 3 no effect", int'(rdata_a), 1);
        bus_op(16'hFFA0, 0, 8'h00, 0, 1, 3'd0);
        check("R3", "clear bit 0", int'(rdata_a), 0);
        bus_op(16'hFFA0, 0, 8'h00, 1, 0, 3'd5);
        check("R3", "set bit 5 no effect", int'(rdata_a), 0);
        bus_op(16'hFFA0, 0, 8'h00, 1, 0, 3'd0);
        check("R3", "set bit 0", int'(rdata_a), 1);
        bus_op(16'hFFA0, 0, 8'h00, 1, 1, 3'd0);
        check("R3", "set wins over clear", int'(rdata_a), 1);
        bus_op(16'hFFA0, 1, 8'h00, 1, 0, 3'd0);
        check("R3", "byte write wins over set", int'(rdata_a), 0);

        // R7 / R8: guarded stop
        phase = "R8";
        main_xtal_sel = 0; sub_sel = 0; step(20);
        bus_op(16'hFFA0, 0, 8'h00, 1, 0, 3'd0);
        check("R8", "stop stored while on ring clock", int'(ring_a), 1);
        check("R8", "stop bit stored", int'(rdata_a), 1);
        main_xtal_sel = 1; #1;
        check("R8", "stop honoured on crystal", int'(ring_a), 0);
        check("R7", "locked build keeps running", int'(ring_b), 1);
        main_xtal_sel = 0; sub_sel = 1; step(20);
        @(negedge clk);
        check("R8", "stop honoured on subsystem", int'(ring_a), 0);
        check("R7", "locked build on subsystem", int'(ring_b), 1);
        sub_sel = 0; step(20);
        @(negedge clk);
        check("R8", "back on ring clock runs", int'(ring_a), 1);
        main_xtal_sel = 1; bus_op(16'hFFA0, 0, 8'h00, 0, 1, 3'd0);
        check("R8", "clear restarts oscillator", int'(ring_a), 1);
        step(10);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule